// File: doc/BRIEF.md
# Serial Port Transmit Controller

This block is the transmit side of a serial port that sends one word per time slot inside a repeating frame. The CPU writes words into a holding store. With the queue mode off, the store is a single data register. With the queue mode on, it is an eight-entry queue with a programmable threshold. At the first bit of every valid slot the transmitter takes the oldest stored word into a shift register and sends it most significant bit first, one bit per bit strobe. The frame start, the slot start, the bit strobe and the slot-valid level all come from outside the block.

Starting and stopping follow the frame structure. Raising the enable has an effect only at a frame start. Dropping it lets the word in flight finish. If no word is waiting when a slot needs one, the previous word is sent again and a sticky underrun flag is set. The block drives a bit-clock gate that is active while a word is in the shifter, or while the enable is high during a valid slot. It raises one of two interrupt lines from the empty condition, and the underrun-interrupt enable picks which line.

Top module: `sptx_ctrl`

## Requirements
- R1: A write (`wr_en`) is accepted when the store holds fewer words than its capacity. The capacity is 1 with `fifo_en`=0 and 8 with `fifo_en`=1. A write to a full store is dropped. `tde` is 1 exactly when the store is empty, whatever the value of `tx_en`. A word written while `tx_en` is low stays stored and is not sent.
- R2: `tfe` is 1 exactly when the number of stored words is less than or equal to `wmark` (0 to 7).
- R3: A slot start is a cycle with `bit_tick`=1 and `slot_start`=1. The transmitter goes from idle to active only at a slot start that has `frame_start`=1 while `tx_en`=1. `ser_oe` equals the active state.
- R4: An active transmitter becomes idle at the first slot start that sees `tx_en`=0. The word already in the shifter still completes before that. If `tx_en` is high again by that slot start, transmission continues without a gap.
- R5: At a slot start where the transmitter is or becomes active and `slot_valid`=1, the oldest stored word is loaded. `ser_dout` then shows its bits MSB first. Each later `bit_tick` advances one bit, and after WORD_W bits `ser_dout` is 0.
- R6: A load with an empty store resends the previously loaded word and sets `urun`. `urun` stays set until an `stat_rd` while it is set is followed, in a later cycle, by a `wr_en`.
- R7: `clk_gate` is 1 while a word still has bits to send, or while `tx_en`=1 and `slot_valid`=1.
- R8: The request flag is `tde` when `fifo_en`=0 and `tfe` when `fifo_en`=1. `irq_exc` = `int_en` & `urun_int_en` & flag, and `irq_data` = `int_en` & ~`urun_int_en` & flag.
- R9: After reset the store is empty, the transmitter is idle, `urun`=0 and `ser_dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe for a transmit word |
| wr_data | input | WORD_W | Word being written |
| stat_rd | input | 1 | CPU status read strobe |
| tx_en | input | 1 | Transmit enable |
| int_en | input | 1 | Interrupt enable |
| urun_int_en | input | 1 | Underrun-interrupt enable (selects the line) |
| fifo_en | input | 1 | Queue mode enable |
| wmark | input | $clog2(DEPTH) | Queue threshold |
| bit_tick | input | 1 | One-cycle strobe per serial bit |
| slot_start | input | 1 | With bit_tick, first bit of a slot |
| frame_start | input | 1 | With a slot start, first slot of a frame |
| slot_valid | input | 1 | Current slot is valid |
| ser_dout | output | 1 | Serial data |
| ser_oe | output | 1 | Serial output enable |
| clk_gate | output | 1 | Bit-clock gate |
| tde | output | 1 | Store empty flag |
| tfe | output | 1 | Queue at or below threshold |
| urun | output | 1 | Sticky underrun flag |
| irq_exc | output | 1 | Transmit interrupt with exception status |
| irq_data | output | 1 | Transmit interrupt without exception |

## Verification
The assertions check these rules on every cycle:
- the output enable rises only at a frame-start slot with the enable high, and falls only at a slot start with the enable low;
- no word is taken from an empty store, and the occupancy never passes eight;
- a write to an empty store always clears the empty flag;
- the underrun flag rises only after a load found the store empty;
- the two interrupt lines are never high together.

The other behaviour can only be shown by the bench's scenarios, because it depends on history: the bit order and the retransmitted word, the finishing of a word after the enable drops, the clearing sequence of the underrun flag, and a word written while disabled being kept and not sent.

// File: rtl/sptx_pkg.sv
package sptx_pkg;

    typedef struct packed {
        logic tick;
        logic slot_start;
        logic frame_start;
        logic slot_valid;
    } slot_strobe_t;

    typedef struct packed {
        logic ld;
        logic pop;
        logic under;
    } load_t;

    function automatic logic slot_edge(slot_strobe_t s);
        return s.tick & s.slot_start;
    endfunction

endpackage

// File: rtl/sptx_store.sv
module sptx_store #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 8,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = PW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              fifo_en,
    input  logic [PW-1:0]     wmark,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              empty,
    output logic              tde,
    output logic              tfe
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0]     rptr, wptr;
    logic [CW-1:0]     cnt, cap;
    logic              acc;

    assign cap   = fifo_en ? CW'(DEPTH) : CW'(1);
    assign acc   = wr_en && (cnt < cap);
    assign head  = mem[rptr];
    assign empty = (cnt == '0);
    assign tde   = empty;
    assign tfe   = (cnt <= {1'b0, wmark});

    always_ff @(posedge clk) begin
        if (acc) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr <= '0;
            wptr <= '0;
            cnt  <= '0;
        end else begin
            if (acc) wptr <= wptr + 1'b1;
            if (pop) rptr <= rptr + 1'b1;
            cnt <= cnt + CW'(acc) - CW'(pop);
        end
    end

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
    a_r1_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        !(pop && empty));
    a_r1_write_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && empty) |=> !tde);
endmodule

// File: rtl/sptx_shift.sv
module sptx_shift
    import sptx_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int LW    = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_strobe_t      strb,
    input  logic              tx_en,
    input  logic              empty,
    input  logic [WORD_W-1:0] head,
    output load_t             lq,
    output logic              ser_dout,
    output logic              ser_oe,
    output logic              clk_gate
);
    logic              active, act_n, edge_s;
    logic [WORD_W-1:0] sh, last;
    logic [LW-1:0]     left;
    logic [WORD_W-1:0] nxt;

    assign edge_s = slot_edge(strb);

    always_comb begin
        act_n = active;
        if (edge_s) act_n = tx_en & (active | strb.frame_start);
    end

    assign lq.ld    = edge_s & act_n & strb.slot_valid;
    assign lq.pop   = lq.ld & ~empty;
    assign lq.under = lq.ld & empty;
    assign nxt      = empty ? last : head;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sh     <= '0;
            last   <= '0;
            left   <= '0;
        end else begin
            active <= act_n;
            if (lq.ld) begin
                sh   <= nxt;
                last <= nxt;
                left <= LW'(WORD_W);
            end else if (strb.tick && left != '0) begin
                left <= left - 1'b1;
                sh   <= {sh[WORD_W-2:0], 1'b0};
            end
        end
    end

    assign ser_dout = (left != '0) & sh[WORD_W-1];
    assign ser_oe   = active;
    assign clk_gate = (left != '0) | (tx_en & strb.slot_valid);

    a_r3_start_at_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_oe) |-> $past(edge_s & strb.frame_start & tx_en));
    a_r4_stop_at_slot: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_oe) |-> $past(edge_s & !tx_en));
endmodule

// File: rtl/sptx_irq.sv
module sptx_irq
    import sptx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  load_t lq,
    input  logic  wr_en,
    input  logic  stat_rd,
    input  logic  tde,
    input  logic  tfe,
    input  logic  fifo_en,
    input  logic  int_en,
    input  logic  urun_int_en,
    output logic  urun,
    output logic  irq_exc,
    output logic  irq_data
);
    logic armed, flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            urun  <= 1'b0;
            armed <= 1'b0;
        end else begin
            urun  <= lq.under | (urun & ~(armed & wr_en));
            armed <= lq.under ? 1'b0 : ((armed & ~wr_en) | (stat_rd & urun));
        end
    end

    assign flag     = fifo_en ? tfe : tde;
    assign irq_exc  = int_en &  urun_int_en & flag;
    assign irq_data = int_en & ~urun_int_en & flag;

    a_r6_urun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(urun) |-> $past(lq.under));
    a_r8_one_line: assert property (@(posedge clk) disable iff (rst)
        !(irq_exc && irq_data));
endmodule

// File: rtl/sptx_ctrl.sv
module sptx_ctrl
    import sptx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 8,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              stat_rd,
    input  logic              tx_en,
    input  logic              int_en,
    input  logic              urun_int_en,
    input  logic              fifo_en,
    input  logic [PW-1:0]     wmark,
    input  logic              bit_tick,
    input  logic              slot_start,
    input  logic              frame_start,
    input  logic              slot_valid,
    output logic              ser_dout,
    output logic              ser_oe,
    output logic              clk_gate,
    output logic              tde,
    output logic              tfe,
    output logic              urun,
    output logic              irq_exc,
    output logic              irq_data
);
    slot_strobe_t      strb;
    load_t             lq;
    logic [WORD_W-1:0] head;
    logic              empty;

    assign strb = '{tick: bit_tick, slot_start: slot_start,
                    frame_start: frame_start, slot_valid: slot_valid};

    sptx_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_en(fifo_en), .wmark(wmark), .pop(lq.pop),
        .head(head), .empty(empty), .tde(tde), .tfe(tfe)
    );

    sptx_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .strb(strb), .tx_en(tx_en),
        .empty(empty), .head(head), .lq(lq),
        .ser_dout(ser_dout), .ser_oe(ser_oe), .clk_gate(clk_gate)
    );

    sptx_irq u_irq (
        .clk(clk), .rst(rst), .lq(lq), .wr_en(wr_en), .stat_rd(stat_rd),
        .tde(tde), .tfe(tfe), .fifo_en(fifo_en), .int_en(int_en),
        .urun_int_en(urun_int_en), .urun(urun),
        .irq_exc(irq_exc), .irq_data(irq_data)
    );
endmodule

// File: tb/sptx_ctrl_bench.sv
module sptx_ctrl_bench;
    localparam int W     = 16;
    localparam int SLOTS = 4;
    localparam int NCYC  = 24000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, stat_rd = 0, tx_en = 0, int_en = 0, urun_int_en = 0, fifo_en = 0;
    logic [W-1:0] wr_data = '0;
    logic [2:0] wmark = '0;
    logic bit_tick = 0, slot_start = 0, frame_start = 0, slot_valid = 0;
    logic ser_dout, ser_oe, clk_gate, tde, tfe, urun, irq_exc, irq_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state
    bit m_act, m_urun, m_armed;
    logic [W-1:0] m_sh, m_last;
    int m_left;
    logic [W-1:0] m_q[$];

    always #2 clk = ~clk;

    sptx_ctrl #(.WORD_W(W), .DEPTH(8)) u_sptx_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .stat_rd(stat_rd),
        .tx_en(tx_en), .int_en(int_en), .urun_int_en(urun_int_en), .fifo_en(fifo_en),
        .wmark(wmark), .bit_tick(bit_tick), .slot_start(slot_start),
        .frame_start(frame_start), .slot_valid(slot_valid),
        .ser_dout(ser_dout), .ser_oe(ser_oe), .clk_gate(clk_gate), .tde(tde),
        .tfe(tfe), .urun(urun), .irq_exc(irq_exc), .irq_data(irq_data)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_flag(bit fe, int n, int wm, bit empty_f);
        return fe ? (n <= wm) : empty_f;
    endfunction

    task automatic model_step();
        int  n   = m_q.size();
        bit  tss = bit_tick & slot_start;
        bit  actn = tss ? (tx_en & (m_act | frame_start)) : m_act;
        bit  ld  = tss & actn & slot_valid;
        bit  pop = ld && n != 0;
        bit  und = ld && n == 0;
        bit  acc = wr_en && n < (fifo_en ? 8 : 1);
        bit  nu  = und | (m_urun & ~(m_armed & wr_en));
        bit  na  = und ? 1'b0 : ((m_armed & ~wr_en) | (stat_rd & m_urun));
        if (ld) begin
            logic [W-1:0] w = pop ? m_q[0] : m_last;
            m_sh = w; m_last = w; m_left = W;
        end else if (bit_tick && m_left != 0) begin
            m_left--; m_sh = {m_sh[W-2:0], 1'b0};
        end
        if (pop) void'(m_q.pop_front());
        if (acc) m_q.push_back(wr_data);
        m_urun = nu; m_armed = na; m_act = actn;
    endtask

    task automatic compare_all();
        int  n  = m_q.size();
        bit  fl = exp_flag(fifo_en, n, int'(wmark), n == 0);
        chk("R1 tde", tde, n == 0);
        chk("R2 tfe", tfe, n <= int'(wmark));
        chk("R3 ser_oe", ser_oe, m_act);
        chk("R5 ser_dout", ser_dout, (m_left != 0) ? m_sh[W-1] : 1'b0);
        chk("R6 urun", urun, m_urun);
        chk("R7 clk_gate", clk_gate, (m_left != 0) | (tx_en & slot_valid));
        chk("R8 irq_exc", irq_exc, int_en & urun_int_en & fl);
        chk("R8 irq_data", irq_data, int_en & ~urun_int_en & fl);
    endtask

    initial begin
        int bitpos = 0;
        void'($urandom(32'h5EED_0A17));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R9: reset state
        chk("R9 tde", tde, 1'b1);
        chk("R9 ser_oe", ser_oe, 1'b0);
        chk("R9 urun", urun, 1'b0);
        chk("R9 ser_dout", ser_dout, 1'b0);
        m_act = 0; m_urun = 0; m_armed = 0; m_sh = '0; m_last = '0; m_left = 0;
        for (int i = 0; i < NCYC; i++) begin
            bit tk = i[0];
            bit ss = 0, fs = 0;
            if (tk) begin
                ss = (bitpos % W) == 0;
                fs = (bitpos % (W * SLOTS)) == 0;
                bitpos = (bitpos + 1) % (W * SLOTS);
            end
            bit_tick = tk; slot_start = ss; frame_start = fs;
            if (ss) slot_valid = ($urandom % 8) != 0;
            if (i < 600) tx_en = 1'b0;
            else if (i >= 600 && i < 700) tx_en = 1'b1;
            else if (($urandom % 250) == 0) tx_en = ~tx_en;
            fifo_en = ((i / 3000) % 2) == 1;
            wmark   = 3'((i / 1500) % 8);
            int_en  = ((i / 700) % 3) != 0;
            urun_int_en = ((i / 1100) % 2) == 1;
            wr_en   = (i < 600) ? (i == 10) :
                      ((($urandom % ((((i / 500) % 3) == 0) ? 100 : 12)) == 0));
            wr_data = 16'($urandom);
            stat_rd = ($urandom % 40) == 0;
            @(posedge clk);
            model_step();
            #1 compare_all();
            if (i == 599) begin
                // R1: word written with tx_en low is kept, not sent
                chk("R1 held while disabled", tde, 1'b0);
                chk("R1 not sent while disabled", ser_oe, 1'b0);
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // R4 is exercised by random tx_en toggling mid-word; R6 by starved phases
    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule